// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer for an always-on power domain. It counts single-cycle ticks of a slow clock that arrive on a tick-enable input. A programmable right shift of 0 to 15 places is applied to the count, and the shifted value is compared with a 16-bit threshold. When a tick takes the shifted count up to the threshold or past it, a sticky pending flag is set. That flag drives an interrupt output. When the reset-enable option is also set, the flag raises a reset request as well.

Software reaches the block through a plain 32-bit register port with write and read strobes and a word address. Every write must come straight after a magic unlock value written to the key register. Any following write uses up the unlock, even a write that changes nothing. A second magic value, written to the feed register, restarts the count. When the zero-on-match option is set, the count restarts by itself at each match, which gives a periodic interrupt.

Word addresses: config 0, count 2, scaled count 4, feed 6, key 7, threshold 8. Any other address reads zero.

Top module: `keyed_wdog`

## Requirements
- R1: After reset every register reads zero, the block is locked, and `irq` and `rst_req` are low.
- R2: Writing 0x0051F15E to the key register (address 7) unlocks the block for exactly one following write to any address. The key register reads 1 while unlocked and 0 otherwise. Writing any other value to the key register leaves the block locked.
- R3: While the block is locked, writes to config (0), count (2), threshold (8) and feed (6) have no effect.
- R4: An unlocked write of 0x0D09F00D to feed clears the count to zero. An unlocked feed write of any other value leaves the count unchanged but still uses up the unlock. Feed always reads 0.
- R5: The count is 31 bits wide. An unlocked write of 0xAAAAAAAA to it reads back as 0x2AAAAAAA.
- R6: Config stores all 32 written bits. Its fields are: shift in [3:0], reset enable in bit 8, zero-on-match in bit 9, always-run in bit 12, run-while-awake in bit 13 and pending in bit 28. Writing all ones reads back all ones, and writing zero reads back zero.
- R7: The scaled-count register (address 4) reads bits [15:0] of the count shifted right by the shift field, with the upper bits zero.
- R8: The count advances by one on each cycle with `lf_tick` high, but only while running. The block runs when always-run is set, or when run-while-awake is set and `core_awake` is high. While not running, the count holds its value, and it resumes from that value when running starts again.
- R9: On a counting tick, if the incremented count shifted by the shift field is greater than or equal to the threshold, pending is set. The count keeps the incremented value unless zero-on-match is set, in which case it becomes 0.
- R10: Pending stays set until an unlocked config write with bit 28 at 0 clears it. If a match occurs in the same cycle as that write, the set takes priority. A later match sets pending again.
- R11: `irq` equals pending, and `rst_req` equals pending AND reset enable.
- R12: `rd_data` loads the addressed register on the clock edge at which `rd_en` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| lf_tick | input | 1 | One-cycle pulse per slow-clock period |
| core_awake | input | 1 | Core-awake qualifier for run-while-awake |
| irq | output | 1 | Interrupt, equal to pending |
| rst_req | output | 1 | Reset request |

## Verification
The assertions assume that `lf_tick`, `core_awake` and the strobes are synchronous to `clk` and single-cycle. They also assume that at most one register write happens per cycle, so the count load, feed clear and config write each come from a distinct write. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It never raises `lf_tick` in the cycle of a count or config write, so the counting and the write-priority properties are exercised without any overlap that would be ambiguous.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] A_CFG    = 4'd0;
  localparam logic [AW-1:0] A_CNT    = 4'd2;
  localparam logic [AW-1:0] A_SCALED = 4'd4;
  localparam logic [AW-1:0] A_FEED   = 4'd6;
  localparam logic [AW-1:0] A_KEY    = 4'd7;
  localparam logic [AW-1:0] A_THR    = 4'd8;
  localparam logic [31:0] UNLOCK_MAGIC = 32'h0051_F15E;
  localparam logic [31:0] FEED_MAGIC   = 32'h0D09_F00D;
  localparam int unsigned B_RST_EN = 8;
  localparam int unsigned B_ZERO   = 9;
  localparam int unsigned B_RUN    = 12;
  localparam int unsigned B_AWAKE  = 13;
  localparam int unsigned B_PEND   = 28;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              open_o,
  output logic              wr_ok_o
);
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(A_KEY);

  logic open_q, open_d;

  // Any write ends the unlock; only the magic key to the key word opens it.
  always_comb begin
    open_d = open_q;
    if (wr_en) open_d = (addr == KEY_ADDR) && (wr_data == DATA_W'(UNLOCK_MAGIC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     open_q <= 1'b0;
    else if (wr_en) open_q <= open_d;
  end

  assign open_o  = open_q;
  assign wr_ok_o = wr_en && open_q && (addr != KEY_ADDR);

  // R2: the unlock is consumed by one non-key write
  a_r2_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != KEY_ADDR) |=> !open_o);
  // R2: a wrong key never opens the block
  a_r2_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data != DATA_W'(UNLOCK_MAGIC)) |=> !open_o);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W   = 31,
  parameter int unsigned SCL_W   = 16,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               run,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [SCL_W-1:0]   thr,
  input  logic               zero_on_hit,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  input  logic               feed_clr,
  output logic [CNT_W-1:0]   count_o,
  output logic [SCL_W-1:0]   scaled_o,
  output logic               hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, inc, inc_sh, cur_sh;
  logic             step;

  assign step   = tick && run;
  assign inc    = cnt_q + CNT_W'(1);
  assign inc_sh = inc >> shift;
  assign cur_sh = cnt_q >> shift;
  assign hit_o  = step && (inc_sh[SCL_W-1:0] >= thr);

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = load_val;
    else if (feed_clr) cnt_d = '0;
    else if (step)     cnt_d = (hit_o && zero_on_hit) ? '0 : inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o  = cnt_q;
  assign scaled_o = cur_sh[SCL_W-1:0];

  // R8: no tick while running and no write means the count holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load && !feed_clr) |=> $stable(count_o));
  // R4: a magic feed always leaves a zero count
  a_r4_feed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_clr && !load) |=> (count_o == '0));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 31,
  parameter int unsigned SCL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hit,
  input  logic              open_i,
  input  logic [CNT_W-1:0]  count,
  input  logic [SCL_W-1:0]  scaled,
  output logic [DATA_W-1:0] cfg_o,
  output logic [SCL_W-1:0]  thr_o,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] cfg_q, cfg_d, rd_q, rd_mux;
  logic [SCL_W-1:0]  thr_q, thr_d;
  logic              cfg_wr, thr_wr;

  assign cfg_wr = wr_ok && (addr == ADDR_W'(A_CFG));
  assign thr_wr = wr_ok && (addr == ADDR_W'(A_THR));

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) cfg_d = wr_data;
    if (hit)    cfg_d[B_PEND] = 1'b1;   // hardware set wins over clear
    thr_d = thr_wr ? wr_data[SCL_W-1:0] : thr_q;
  end

  always_comb begin
    unique case (addr)
      ADDR_W'(A_CFG):    rd_mux = cfg_q;
      ADDR_W'(A_CNT):    rd_mux = DATA_W'(count);
      ADDR_W'(A_SCALED): rd_mux = DATA_W'(scaled);
      ADDR_W'(A_KEY):    rd_mux = DATA_W'(open_i);
      ADDR_W'(A_THR):    rd_mux = DATA_W'(thr_q);
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      thr_q <= '0;
      rd_q  <= '0;
    end else begin
      cfg_q <= cfg_d;
      thr_q <= thr_d;
      if (rd_en) rd_q <= rd_mux;
    end
  end

  assign cfg_o   = cfg_q;
  assign thr_o   = thr_q;
  assign rd_data = rd_q;

  // R10: pending is sticky without a config write
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o[B_PEND] && !cfg_wr) |=> cfg_o[B_PEND]);
  // R9: a match always leaves pending set
  a_r9_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cfg_o[B_PEND]);
  // R12: read data only moves on a read strobe
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 31,
  parameter int unsigned SCL_W   = 16,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lf_tick,
  input  logic              core_awake,
  output logic              irq,
  output logic              rst_req
);
  logic              open_s, wr_ok, hit, run, load, feed_clr;
  logic [DATA_W-1:0] cfg;
  logic [SCL_W-1:0]  thr, scaled;
  logic [CNT_W-1:0]  count;

  assign load     = wr_ok && (addr == ADDR_W'(A_CNT));
  assign feed_clr = wr_ok && (addr == ADDR_W'(A_FEED)) && (wr_data == DATA_W'(FEED_MAGIC));
  assign run      = cfg[B_RUN] || (cfg[B_AWAKE] && core_awake);

  wdog_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_unlock (
    .clk, .rst_n, .wr_en, .addr, .wr_data, .open_o(open_s), .wr_ok_o(wr_ok)
  );

  wdog_counter #(.CNT_W(CNT_W), .SCL_W(SCL_W), .SHIFT_W(SHIFT_W)) u_cnt (
    .clk, .rst_n, .tick(lf_tick), .run, .shift(cfg[SHIFT_W-1:0]), .thr,
    .zero_on_hit(cfg[B_ZERO]), .load, .load_val(wr_data[CNT_W-1:0]),
    .feed_clr, .count_o(count), .scaled_o(scaled), .hit_o(hit)
  );

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SCL_W(SCL_W)) u_regs (
    .clk, .rst_n, .wr_ok, .rd_en, .addr, .wr_data, .hit, .open_i(open_s),
    .count, .scaled, .cfg_o(cfg), .thr_o(thr), .rd_data
  );

  assign irq     = cfg[B_PEND];
  assign rst_req = cfg[B_PEND] && cfg[B_RST_EN];

  // R11: a reset request implies a pending interrupt
  a_r11_req_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> irq);
  // R3: a locked threshold write leaves the threshold alone
  a_r3_locked_thr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !open_s && addr == ADDR_W'(A_THR)) |=> $stable(thr));
endmodule

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [3:0] CFG = 4'd0, CNT = 4'd2, SCL = 4'd4, FEED = 4'd6, KEY = 4'd7, THR = 4'd8;
  localparam logic [31:0] KMAG = 32'h0051_F15E, FMAG = 32'h0D09_F00D;
  localparam logic [31:0] RUN = 32'h0000_1000, AWAKE = 32'h0000_2000,
                          ZERO = 32'h0000_0200, RSTEN = 32'h0000_0100;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, lf_tick = 1'b0, core_awake = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq, rst_req;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdog u0 (.clk, .rst_n, .wr_en, .rd_en, .addr, .wr_data, .rd_data,
                 .lf_tick, .core_awake, .irq, .rst_req);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic uwr(input logic [3:0] a, input logic [31:0] d);
    wr(KEY, KMAG); wr(a, d);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lf_tick = 1'b1;
      @(negedge clk); lf_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(CFG, v); chk("R1 cfg", v, 0);
    rd(CNT, v); chk("R1 count", v, 0);
    rd(THR, v); chk("R1 thr", v, 0);
    rd(KEY, v); chk("R1 key", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rst_req", {31'b0, rst_req}, 0);
  endtask

  task automatic t_key();
    logic [31:0] v;
    wr(KEY, 32'h0000_FFFF); rd(KEY, v); chk("R2 bad key", v, 0);
    wr(KEY, KMAG); rd(KEY, v); chk("R2 open", v, 1);
    wr(FEED, 32'hAAAA_AAAA); rd(KEY, v); chk("R2 consumed by feed (R4)", v, 0);
    wr(KEY, KMAG); wr(SCL, 32'h1); rd(KEY, v); chk("R2 consumed by any write", v, 0);
  endtask

  task automatic t_locked();
    logic [31:0] v;
    wr(CFG, 32'hFFFF_FFFF); rd(CFG, v); chk("R3 locked cfg", v, 0);
    wr(THR, 32'hBEEF); rd(THR, v); chk("R3 locked thr", v, 0);
    wr(CNT, 32'hBEEF); rd(CNT, v); chk("R3 locked count", v, 0);
    uwr(CNT, 32'd5);
    wr(FEED, FMAG); rd(CNT, v); chk("R3 locked feed", v, 5);
    uwr(THR, 32'hBEEF); rd(THR, v); chk("R3 unlocked thr", v, 32'hBEEF);
  endtask

  task automatic t_count_feed();
    logic [31:0] v;
    uwr(CNT, 32'hAAAA_AAAA); rd(CNT, v); chk("R5 width", v, 32'h2AAA_AAAA);
    uwr(FEED, 32'hAAAA_AAAA); rd(CNT, v); chk("R4 wrong feed", v, 32'h2AAA_AAAA);
    uwr(FEED, FMAG); rd(CNT, v); chk("R4 feed clears", v, 0);
    rd(FEED, v); chk("R4 feed reads 0", v, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    uwr(CFG, 32'hFFFF_FFFF); rd(CFG, v); chk("R6 all ones", v, 32'hFFFF_FFFF);
    chk("R11 irq", {31'b0, irq}, 1);
    chk("R11 rst_req", {31'b0, rst_req}, 1);
    uwr(CFG, 32'h0); rd(CFG, v); chk("R6 zero", v, 0);
    chk("R10 cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_scale();
    logic [31:0] v;
    uwr(CNT, 32'h1234_5678);
    for (int s = 0; s < 16; s++) begin
      uwr(CFG, 32'(s)); rd(SCL, v);
      chk($sformatf("R7 shift %0d", s), v, (32'h1234_5678 >> s) & 32'hFFFF);
    end
  endtask

  task automatic t_run();
    logic [31:0] v;
    uwr(CNT, 0); uwr(THR, 5); uwr(CFG, RUN);
    ticks(4); rd(CNT, v); chk("R8 four ticks", v, 4);
    chk("R9 no early match", {31'b0, irq}, 0);
    ticks(1); chk("R9 match sets irq", {31'b0, irq}, 1);
    chk("R11 no rst without enable", {31'b0, rst_req}, 0);
    ticks(2); rd(CNT, v); chk("R9 runs past match", v, 7);
    uwr(CFG, RUN); chk("R10 sw clear", {31'b0, irq}, 0);
    ticks(1); chk("R10 re-set", {31'b0, irq}, 1);
    uwr(CFG, 0); ticks(3); rd(CNT, v); chk("R8 frozen", v, 8);
    uwr(CFG, RUN); ticks(2); rd(CNT, v); chk("R8 resumes", v, 10);
  endtask

  task automatic t_awake();
    logic [31:0] v;
    uwr(THR, 32'hFFFF); uwr(CNT, 0); uwr(CFG, AWAKE);
    core_awake = 1'b0; ticks(2); rd(CNT, v); chk("R8 asleep holds", v, 0);
    core_awake = 1'b1; ticks(2); rd(CNT, v); chk("R8 awake counts", v, 2);
    core_awake = 1'b0;
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    uwr(CFG, 0); uwr(CNT, 0); uwr(THR, 3); uwr(CFG, RUN | ZERO);
    ticks(2); rd(CNT, v); chk("R9 before wrap", v, 2);
    ticks(1); rd(CNT, v); chk("R9 zero on match", v, 0);
    chk("R9 periodic irq", {31'b0, irq}, 1);
    ticks(1); rd(CNT, v); chk("R9 restarts", v, 1);
  endtask

  task automatic t_scaled_match();
    logic [31:0] v;
    uwr(CFG, 0); uwr(CNT, 0); uwr(THR, 2); uwr(CFG, RUN | 32'd2);
    ticks(7); chk("R9 scaled 1 below", {31'b0, irq}, 0);
    ticks(1); chk("R9 scaled 2 hits", {31'b0, irq}, 1);
    rd(SCL, v); chk("R7 scaled after 8", v, 2);
  endtask

  task automatic t_rstreq();
    uwr(CFG, 0); uwr(CNT, 0); uwr(THR, 1); uwr(CFG, RUN | RSTEN);
    chk("R11 idle", {31'b0, rst_req}, 0);
    ticks(1); chk("R11 request", {31'b0, rst_req}, 1);
    uwr(CFG, 0); chk("R11 released", {31'b0, rst_req}, 0);
  endtask

  task automatic t_read_hold();
    logic [31:0] v;
    uwr(CNT, 32'h55); rd(CNT, v); chk("R12 read", v, 32'h55);
    uwr(CNT, 32'h66); @(negedge clk); chk("R12 holds", rd_data, 32'h55);
    rd(4'd1, v); chk("R12 unmapped", v, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_key();
    t_locked();
    t_count_feed();
    t_cfg();
    t_scale();
    t_run();
    t_awake();
    t_periodic();
    t_scaled_match();
    t_rstreq();
    t_read_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule